// File: doc/BRIEF.md
# Four-Channel Self-Disarming Alarm Unit

The unit holds four alarm channels that each compare a 32-bit target against the low word of a free-running timebase supplied from outside. Software arms a channel simply by writing its target. On the first clock edge where an armed channel's target equals the time input, the channel latches a raw interrupt bit and drops its own armed flag. Software can then re-arm it by writing a new target.

A shared armed-status word lets software see which channels are still waiting, and cancel any of them early by writing ones. Interrupts are handled in three layers: raw bits that software clears by writing ones, a per-channel enable mask, and a per-channel force mask. The masked status combines all three and drives one interrupt line per channel.

The register port is a single-cycle write strobe with an address and data word, plus a combinational read-data output for the same address.

Top module: `alarm_unit`

## Requirements
- R1: After reset every armed, raw, enable and force bit is zero, every target is zero, and `irq_o` is low.
- R2: A write to offset 0x10 + 4*n stores the data as the target of channel n and sets armed bit n at that edge. The target reads back at the same offset.
- R3: When channel n is armed and its target equals `time_lo` at a clock edge, raw bit n sets and armed bit n clears at that same edge.
- R4: Writing the armed-status word at offset 0x20 (bit n = channel n) with a one in bit n disarms channel n at that edge, and does not set raw bit n.
- R5: A disarmed channel never sets its raw bit, even when its target equals `time_lo`.
- R6: Raw bits read at offset 0x34 (bit n = channel n). Writing a one clears that bit. If a fire and a clearing write meet in the same cycle, the bit ends up set.
- R7: Enable (0x38) and force (0x3C) are read/write masks. Status at 0x40 is bit n = (raw n AND enable n) OR force n, and `irq_o[n]` equals status bit n.
- R8: A target write to channel n in the same cycle that channel n fires leaves channel n armed with the new target, and raw bit n still sets.
- R9: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 7 | Byte offset of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| time_lo | input | 32 | Low word of the running timebase |
| irq_o | output | 4 | One interrupt per channel, equal to the status bits |

## Verification
A channel whose armed flag is wrong shows up in two ways. The armed-status word reads wrong in the cycle after the bad edge. A missed or spurious fire reaches the raw word and the interrupt line one edge after the time match. A raw, enable or force bit held wrongly shows up at once on `irq_o` and in the status word, because both are derived without a register stage. Races between priorities (fire against clear, fire against re-arm) leave a wrong bit on the very next read, so each such case is checked one cycle after the contested edge.

// File: rtl/alarm_unit_pkg.sv
package alarm_unit_pkg;
    localparam int ALARM_COUNT = 4;
    localparam int WORD_W      = 32;
    localparam int OFS_W       = 7;

    // register offsets decoded by software drivers
    localparam logic [OFS_W-1:0] OFS_TARGET0 = 7'h10;
    localparam int               TARGET_STEP = 4;
    localparam logic [OFS_W-1:0] OFS_ARMED   = 7'h20;
    localparam logic [OFS_W-1:0] OFS_RAW     = 7'h34;
    localparam logic [OFS_W-1:0] OFS_ENABLE  = 7'h38;
    localparam logic [OFS_W-1:0] OFS_FORCE   = 7'h3C;
    localparam logic [OFS_W-1:0] OFS_STATUS  = 7'h40;
endpackage

// File: rtl/alarm_slot.sv
module alarm_slot #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] new_target,
    input  logic          disarm,
    input  logic [TW-1:0] now,
    output logic [TW-1:0] target_o,
    output logic          armed_o,
    output logic          fire_o
);
    typedef struct packed {
        logic [TW-1:0] target;
        logic          armed;
    } slot_t;

    slot_t s_d, s_q;
    logic  hit;

    always_comb begin
        hit = s_q.armed && (s_q.target == now);
        s_d = s_q;
        if (hit || disarm) s_d.armed = 1'b0;
        // arming from a target write outranks both disarm sources
        if (load) begin
            s_d.target = new_target;
            s_d.armed  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign target_o = s_q.target;
    assign armed_o  = s_q.armed;
    assign fire_o   = hit;
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire,
    input  logic         wr_raw,
    input  logic         wr_en,
    input  logic         wr_frc,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] en_o,
    output logic [N-1:0] frc_o,
    output logic [N-1:0] status_o
);
    typedef struct packed {
        logic [N-1:0] raw;
        logic [N-1:0] en;
        logic [N-1:0] frc;
    } irq_t;

    irq_t r_d, r_q;
    logic [N-1:0] clr;

    always_comb begin
        clr   = wr_raw ? wbits : '0;
        r_d   = r_q;
        // a new fire beats a clearing write in the same cycle
        r_d.raw = (r_q.raw & ~clr) | fire;
        if (wr_en)  r_d.en  = wbits;
        if (wr_frc) r_d.frc = wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign raw_o    = r_q.raw;
    assign en_o     = r_q.en;
    assign frc_o    = r_q.frc;
    assign status_o = (r_q.raw & r_q.en) | r_q.frc;
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import alarm_unit_pkg::*;
#(
    parameter int N  = ALARM_COUNT,
    parameter int DW = WORD_W,
    parameter int AW = OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] time_lo,
    output logic [N-1:0]  irq_o
);
    logic [N-1:0]  tgt_load;
    logic [N-1:0]  disarm_mask;
    logic [N-1:0]  fire;
    logic [N-1:0]  armed;
    logic [N-1:0]  raw;
    logic [N-1:0]  en;
    logic [N-1:0]  frc;
    logic [N-1:0]  status;
    logic [DW-1:0] tgt [N];
    logic          hit_armed, hit_raw, hit_en, hit_frc;

    assign hit_armed   = reg_wr && (reg_addr == AW'(OFS_ARMED));
    assign hit_raw     = reg_wr && (reg_addr == AW'(OFS_RAW));
    assign hit_en      = reg_wr && (reg_addr == AW'(OFS_ENABLE));
    assign hit_frc     = reg_wr && (reg_addr == AW'(OFS_FORCE));
    assign disarm_mask = hit_armed ? reg_wdata[N-1:0] : '0;

    for (genvar g = 0; g < N; g++) begin : g_slot
        localparam logic [AW-1:0] SLOT_OFS = AW'(int'(OFS_TARGET0) + g * TARGET_STEP);
        assign tgt_load[g] = reg_wr && (reg_addr == SLOT_OFS);

        alarm_slot #(.TW(DW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (tgt_load[g]),
            .new_target (reg_wdata),
            .disarm     (disarm_mask[g]),
            .now        (time_lo),
            .target_o   (tgt[g]),
            .armed_o    (armed[g]),
            .fire_o     (fire[g])
        );
    end

    alarm_irq #(.N(N)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .wr_raw   (hit_raw),
        .wr_en    (hit_en),
        .wr_frc   (hit_frc),
        .wbits    (reg_wdata[N-1:0]),
        .raw_o    (raw),
        .en_o     (en),
        .frc_o    (frc),
        .status_o (status)
    );

    assign irq_o = status;

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (reg_addr == AW'(int'(OFS_TARGET0) + i * TARGET_STEP)) reg_rdata = tgt[i];
        end
        if (reg_addr == AW'(OFS_ARMED))  reg_rdata = DW'(armed);
        if (reg_addr == AW'(OFS_RAW))    reg_rdata = DW'(raw);
        if (reg_addr == AW'(OFS_ENABLE)) reg_rdata = DW'(en);
        if (reg_addr == AW'(OFS_FORCE))  reg_rdata = DW'(frc);
        if (reg_addr == AW'(OFS_STATUS)) reg_rdata = DW'(status);
    end
endmodule

// File: rtl/alarm_unit_chk.sv
module alarm_unit_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] load,
    input logic [N-1:0] disarm,
    input logic [N-1:0] fire,
    input logic [N-1:0] armed,
    input logic [N-1:0] raw,
    input logic [N-1:0] frc,
    input logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
            load[i] |=> armed[i]); // R2
        AST_FIRE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> raw[i]); // R3
        AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] && !load[i] |=> !armed[i]); // R3
        AST_EARLY_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
            disarm[i] && !load[i] |=> !armed[i]); // R4
        AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !armed[i] |=> !$rose(raw[i])); // R5
        AST_FORCE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            frc[i] |-> irq[i]); // R7
        AST_REARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] && load[i] |=> armed[i] && raw[i]); // R8
    end
endmodule

bind alarm_unit alarm_unit_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tgt_load),
    .disarm (disarm_mask),
    .fire   (fire),
    .armed  (armed),
    .raw    (raw),
    .frc    (frc),
    .irq    (irq_o)
);

// File: tb/alarm_unit_bench.sv
`timescale 1ns/1ps
module alarm_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] time_lo = '0;
    logic [3:0]  irq_o;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    alarm_unit u_alarm_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_lo(time_lo), .irq_o(irq_o)
    );

    // fields: tag[76:73] is_read[72] addr[71:64] data_or_expect[63:32] time[31:0]
    localparam int NV = 22;
    localparam logic [76:0] VEC [NV] = '{
        {4'd2, 1'b0, 8'h38, 32'hF,   32'd0},   // R2 enable all
        {4'd2, 1'b0, 8'h10, 32'd100, 32'd0},   // R2 arm ch0
        {4'd2, 1'b1, 8'h10, 32'd100, 32'd0},   // R2 target readback
        {4'd2, 1'b1, 8'h20, 32'd1,   32'd100}, // R2 armed, match at this edge
        {4'd3, 1'b1, 8'h20, 32'd0,   32'd101}, // R3 self-disarmed
        {4'd3, 1'b1, 8'h34, 32'd1,   32'd101}, // R3 raw set
        {4'd7, 1'b1, 8'h40, 32'd1,   32'd0},   // R7 status
        {4'd4, 1'b0, 8'h14, 32'd200, 32'd0},   // R4 arm ch1
        {4'd4, 1'b0, 8'h20, 32'd2,   32'd0},   // R4 disarm ch1
        {4'd5, 1'b1, 8'h20, 32'd0,   32'd200}, // R5 disarmed, time matches
        {4'd5, 1'b1, 8'h34, 32'd1,   32'd200}, // R5 no raw for ch1
        {4'd6, 1'b0, 8'h34, 32'd1,   32'd0},   // R6 clear raw0
        {4'd6, 1'b1, 8'h34, 32'd0,   32'd0},   // R6
        {4'd7, 1'b0, 8'h3C, 32'd8,   32'd0},   // R7 force ch3
        {4'd7, 1'b1, 8'h40, 32'd8,   32'd0},   // R7
        {4'd7, 1'b1, 8'h3C, 32'd8,   32'd0},   // R7 force readback
        {4'd7, 1'b0, 8'h38, 32'd0,   32'd0},   // R7 disable all
        {4'd7, 1'b0, 8'h3C, 32'd0,   32'd0},   // R7 unforce
        {4'd3, 1'b0, 8'h18, 32'd50,  32'd50},  // R3 arm ch2 while time already equal
        {4'd3, 1'b1, 8'h20, 32'd4,   32'd50},  // R3 armed, fires at this edge
        {4'd3, 1'b1, 8'h34, 32'd4,   32'd0},   // R3 raw2
        {4'd7, 1'b1, 8'h40, 32'd0,   32'd0}    // R7 masked out
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [31:0] t);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; time_lo = t;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [6:0] a, input logic [31:0] exp, input logic [31:0] t);
        reg_wr = 1'b0; reg_addr = a; time_lo = t;
        #1;
        check(req, reg_rdata, exp);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd("R1", 7'h20, 0, 0);
        rd("R1", 7'h34, 0, 0);
        rd("R1", 7'h38, 0, 0);
        rd("R1", 7'h3C, 0, 0);
        rd("R1", 7'h40, 0, 0);
        rd("R1", 7'h1C, 0, 0);
        check("R1", {28'd0, irq_o}, 0);
        // table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i][76:73]);
            if (VEC[i][72]) rd(tag, VEC[i][70:64], VEC[i][63:32], VEC[i][31:0]);
            else            wr(VEC[i][70:64], VEC[i][63:32], VEC[i][31:0]);
        end
        // R9 unmapped offset
        rd("R9", 7'h2C, 0, 0);
        rd("R9", 7'h44, 0, 0);
        // R8 re-arm in the firing cycle
        wr(7'h1C, 32'd7, 0);
        wr(7'h1C, 32'd9, 32'd7);
        rd("R8", 7'h20, 32'h8, 0);
        rd("R8", 7'h34, 32'hC, 0);
        rd("R8", 7'h1C, 32'd9, 32'd9);   // fires on the new target here
        rd("R8", 7'h20, 32'h0, 0);
        // R6 fire and clear meet in one cycle: bit stays set
        wr(7'h10, 32'd30, 0);
        wr(7'h34, 32'h1, 32'd30);
        rd("R6", 7'h34, 32'hD, 0);
        // R7 interrupt pin follows masked status
        wr(7'h38, 32'h1, 0);
        #1;
        check("R7", {28'd0, irq_o}, 32'h1);
        wr(7'h3C, 32'h2, 0);
        #1;
        check("R7", {28'd0, irq_o}, 32'h3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule